// File: doc/BRIEF.md
# Selectable Apodization and Channel Summer

This block forms one beam sample per sample period from the fine-delayed outputs of an array of receive channels. Each channel sample is a signed 32-bit integer. It is multiplied by a signed Q1.31 apodization weight, which gives a 64-bit product. The weights come from a small bank of window tables, such as Hanning, Hamming and Kaiser shapes. The window tables are computed offline and written in through a load port. A table is picked by a window-select input and indexed by channel number. The weighted products go through a registered binary adder tree, which adds them into one 64-bit beam sample. A valid flag travels down the tree beside the data.

The window select is captured only on the first sample of a scan line, so a line is never weighted with a mix of two windows. Finished beam samples are written into a double-buffered store. One half fills at consecutive addresses while the other half can be read. After a programmable number of beam samples the halves swap, and a ready flag marks the half that has just completed.

The reset input is active low. It is asserted asynchronously and is expected to be released synchronously to `clk` by the reset logic upstream.

Top module: `apod_beam_summer`

## Requirements
- R1: While reset is held and after it is released, `beam_valid` is 0, `half_ready` is 2'b00, `fill_half` is 0 and the active window is window 0.
- R2: Each beam sample equals the sum, over all channels c, of the signed 32-bit sample in `ch_data[c*32 +: 32]` times the signed 32-bit weight of the active window for channel c. The sum is kept to 64 bits in two's complement.
- R3: `beam_valid` rises exactly 1+log2(NUM_CH) cycles after the clock edge that accepts an `in_valid` sample. Each accepted sample gives exactly one output, including samples on back-to-back cycles and samples separated by gaps.
- R4: The active window takes the value of `win_sel` only at an edge where `in_valid` and `line_start` are both 1, and that sample is weighted with the new window. At any other edge, a change on `win_sel` or `line_start` has no effect.
- R5: When `wt_we` is 1 at an edge, the weight for window `wt_win`, channel `wt_ch` becomes `wt_data`. Samples accepted at later edges use the new value.
- R6: Beam samples are written into the filling half at addresses 0, 1, 2 and so on. On the write at the last address, the halves swap: `half_ready[h]` is set for the half h just completed (bit 0 is half 0), and the other bit is cleared. The last address is `beam_len`-1. A `beam_len` of 0 acts as 1, and a `beam_len` above DEPTH acts as DEPTH.
- R7: When `rd_en` is 1, `rd_data` shows, one cycle later, the entry at `rd_addr` in the half that is not filling. When `rd_en` is 0, `rd_data` holds its value.
- R8: At most one bit of `half_ready` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Channel samples present this cycle |
| line_start | input | 1 | Sample is the first of a scan line |
| win_sel | input | log2(NUM_WIN) | Requested window table |
| ch_data | input | NUM_CH*SAMP_W | Fine-delayed channel samples, channel c at bits c*SAMP_W |
| wt_we | input | 1 | Weight table write strobe |
| wt_win | input | log2(NUM_WIN) | Window being written |
| wt_ch | input | log2(NUM_CH) | Channel being written |
| wt_data | input | WT_W | Q1.31 weight value |
| beam_len | input | log2(DEPTH)+1 | Beam samples per buffer half |
| rd_en | input | 1 | Read strobe for the completed half |
| rd_addr | input | log2(DEPTH) | Read address within the half |
| beam_valid | output | 1 | Beam sample valid |
| beam_data | output | SAMP_W+WT_W | Summed beam sample |
| fill_half | output | 1 | Half currently filling |
| half_ready | output | 2 | Completed-half flags |
| rd_data | output | SAMP_W+WT_W | Registered read data |

## Verification
The bench builds the block with 8 channels, 4 windows and 4-entry buffer halves. With these values the adder tree has three levels, so the latency of 4 cycles can be counted exactly for every output. The small halves let a short stream of samples swap the buffer several times. They also make both length clamps reachable: a length of 0 swaps after every sample, and a length of 7 swaps after 4 samples. Weights are chosen per window and channel, some of them negative, so a wrong window, a wrong channel or a stale weight changes the sum.

// File: rtl/apod_pkg.sv
package apod_pkg;

  // Elaboration helper: the tree and the buffer need power-of-two sizes.
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Beam sample width for a given sample and weight width.
  function automatic int unsigned prod_width(input int unsigned sw, input int unsigned ww);
    return sw + ww;
  endfunction

endpackage

// File: rtl/apod_weight_store.sv
module apod_weight_store #(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned WT_W    = 32,
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned WIN_W  = $clog2(NUM_WIN),
  localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wt_we,
  input  logic [WIN_W-1:0]         wt_win,
  input  logic [CH_W-1:0]          wt_ch,
  input  logic [WT_W-1:0]          wt_data,
  input  logic                     in_valid,
  input  logic                     line_start,
  input  logic [WIN_W-1:0]         win_sel,
  output logic [NUM_CH*WT_W-1:0]   wts
);

  logic [WT_W-1:0]  w_mem [NUM_WIN][NUM_CH];
  logic [WIN_W-1:0] act_win, act_win_nxt, eff_win;
  logic             take_sel;

  // Table load: plain storage, no reset
  always_ff @(posedge clk) begin
    if (wt_we) w_mem[wt_win][wt_ch] <= wt_data;
  end

  // Window capture at scan line start only
  assign take_sel = in_valid && line_start;

  always_comb begin
    act_win_nxt = act_win;
    if (take_sel) act_win_nxt = win_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_win <= '0;
    else        act_win <= act_win_nxt;
  end

  // The sample that starts a line already uses the newly selected window
  assign eff_win = take_sel ? win_sel : act_win;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wt
    assign wts[c*WT_W +: WT_W] = w_mem[eff_win][c];
  end

  // R4: window held between line starts
  assert_win_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && line_start) |=> $stable(act_win));

  // R4: window taken from the select at a line start
  assert_win_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && line_start) |=> (act_win == $past(win_sel)));

endmodule

// File: rtl/apod_weight_sum.sv
module apod_weight_sum #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned SAMP_W = 32,
  parameter int unsigned WT_W   = 32,
  localparam int unsigned LEVELS = $clog2(NUM_CH),
  localparam int unsigned PROD_W = apod_pkg::prod_width(SAMP_W, WT_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [NUM_CH*SAMP_W-1:0]   ch_data,
  input  logic [NUM_CH*WT_W-1:0]     wts,
  output logic                       out_valid,
  output logic [PROD_W-1:0]          out_sum
);

  logic signed [PROD_W-1:0] prod [NUM_CH];
  logic [LEVELS:0]          vld;

  // Valid pipeline, one stage per register level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[LEVELS-1:0], in_valid};
  end

  // Weighting stage: signed sample times signed Q1.31 weight
  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int c = 0; c < NUM_CH; c++) begin
        prod[c] <= $signed(ch_data[c*SAMP_W +: SAMP_W]) * $signed(wts[c*WT_W +: WT_W]);
      end
    end
  end

  // Registered pairwise adder tree, one level per stage
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned CNT = NUM_CH >> (l + 1);
    logic signed [PROD_W-1:0] node [CNT];
    if (l == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (vld[0]) begin
          for (int i = 0; i < CNT; i++) node[i] <= prod[2*i] + prod[2*i+1];
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (vld[l]) begin
          for (int i = 0; i < CNT; i++) node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
        end
      end
    end
  end

  assign out_sum   = g_lvl[LEVELS-1].node[0];
  assign out_valid = vld[LEVELS];

  // R3: a valid output only follows a valid weighting stage
  assert_tree_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(vld[LEVELS-1]));

endmodule

// File: rtl/apod_pingpong.sv
module apod_pingpong #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   beam_len,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fill_half,
  output logic [1:0]        half_ready
);

  logic [DATA_W-1:0] mem [2][DEPTH];
  logic [ADDR_W-1:0] wr_addr, wr_addr_nxt, last_idx;
  logic              fill_nxt, at_last;
  logic [1:0]        ready_nxt;

  // Length clamp: 0 behaves as 1, above DEPTH behaves as DEPTH
  always_comb begin
    if (beam_len == '0)                         last_idx = '0;
    else if (beam_len >= (ADDR_W+1)'(DEPTH))    last_idx = ADDR_W'(DEPTH - 1);
    else                                        last_idx = ADDR_W'(beam_len - 1'b1);
  end

  assign at_last = (wr_addr >= last_idx);

  always_comb begin
    wr_addr_nxt = wr_addr;
    fill_nxt    = fill_half;
    ready_nxt   = half_ready;
    if (wr_valid) begin
      if (at_last) begin
        wr_addr_nxt = '0;
        fill_nxt    = ~fill_half;
        ready_nxt   = fill_half ? 2'b10 : 2'b01;
      end else begin
        wr_addr_nxt = wr_addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr    <= '0;
      fill_half  <= 1'b0;
      half_ready <= 2'b00;
    end else begin
      wr_addr    <= wr_addr_nxt;
      fill_half  <= fill_nxt;
      half_ready <= ready_nxt;
    end
  end

  // Storage and read port
  always_ff @(posedge clk) begin
    if (wr_valid) mem[fill_half][wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[~fill_half][rd_addr];
  end

  assert_one_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(half_ready));

  assert_swap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && at_last) |=> (fill_half != $past(fill_half)) && half_ready[$past(fill_half)]);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(fill_half) && $stable(wr_addr) && $stable(half_ready));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !at_last) |=> (wr_addr == $past(wr_addr) + 1'b1));

endmodule

// File: rtl/apod_beam_summer.sv
module apod_beam_summer #(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned SAMP_W  = 32,
  parameter int unsigned WT_W    = 32,
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned DEPTH   = 64,
  localparam int unsigned WIN_W  = $clog2(NUM_WIN),
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PROD_W = apod_pkg::prod_width(SAMP_W, WT_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      line_start,
  input  logic [WIN_W-1:0]          win_sel,
  input  logic [NUM_CH*SAMP_W-1:0]  ch_data,
  input  logic                      wt_we,
  input  logic [WIN_W-1:0]          wt_win,
  input  logic [CH_W-1:0]           wt_ch,
  input  logic [WT_W-1:0]           wt_data,
  input  logic [ADDR_W:0]           beam_len,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic                      beam_valid,
  output logic [PROD_W-1:0]         beam_data,
  output logic                      fill_half,
  output logic [1:0]                half_ready,
  output logic [PROD_W-1:0]         rd_data
);

  if (!apod_pkg::is_pow2(NUM_CH) || NUM_CH < 2 || !apod_pkg::is_pow2(DEPTH) || DEPTH < 2
      || !apod_pkg::is_pow2(NUM_WIN) || NUM_WIN < 2) begin : g_bad_cfg
    $error("apod_beam_summer: NUM_CH, NUM_WIN and DEPTH must be powers of two, at least 2");
  end

  logic [NUM_CH*WT_W-1:0] wts;

  apod_weight_store #(.NUM_CH(NUM_CH), .WT_W(WT_W), .NUM_WIN(NUM_WIN)) u_wstore (
    .clk        (clk),
    .rst_n      (rst_n),
    .wt_we      (wt_we),
    .wt_win     (wt_win),
    .wt_ch      (wt_ch),
    .wt_data    (wt_data),
    .in_valid   (in_valid),
    .line_start (line_start),
    .win_sel    (win_sel),
    .wts        (wts)
  );

  apod_weight_sum #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .WT_W(WT_W)) u_wsum (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ch_data   (ch_data),
    .wts       (wts),
    .out_valid (beam_valid),
    .out_sum   (beam_data)
  );

  apod_pingpong #(.DEPTH(DEPTH), .DATA_W(PROD_W)) u_pp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (beam_valid),
    .wr_data    (beam_data),
    .beam_len   (beam_len),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .fill_half  (fill_half),
    .half_ready (half_ready)
  );

  // R1: nothing is flagged in the cycle after a reset release
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !beam_valid && (half_ready == 2'b00));

endmodule

// File: tb/apod_beam_summer_tb.sv
module apod_beam_summer_tb;

  localparam int NCH = 8;
  localparam int NWIN = 4;
  localparam int DEP = 4;
  localparam int LAT = 1 + $clog2(NCH);

  typedef struct packed {
    logic              ls;
    logic [1:0]        win;
    logic signed [31:0] seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 32'sd100},
    '{1'b0, 2'd2, -32'sd7},
    '{1'b0, 2'd3, 32'sd5000},
    '{1'b1, 2'd1, 32'sd3},
    '{1'b0, 2'd0, -32'sd20000},
    '{1'b1, 2'd3, 32'sd77},
    '{1'b0, 2'd1, -32'sd1},
    '{1'b1, 2'd2, 32'sd32767}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, line_start;
  logic [1:0]        win_sel;
  logic [NCH*32-1:0] ch_data;
  logic              wt_we;
  logic [1:0]        wt_win;
  logic [2:0]        wt_ch;
  logic [31:0]       wt_data;
  logic [2:0]        beam_len;
  logic              rd_en;
  logic [1:0]        rd_addr;
  logic              beam_valid;
  logic [63:0]       beam_data;
  logic              fill_half;
  logic [1:0]        half_ready;
  logic [63:0]       rd_data;

  apod_beam_summer #(.NUM_CH(NCH), .SAMP_W(32), .WT_W(32), .NUM_WIN(NWIN), .DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .line_start(line_start), .win_sel(win_sel),
    .ch_data(ch_data), .wt_we(wt_we), .wt_win(wt_win), .wt_ch(wt_ch), .wt_data(wt_data),
    .beam_len(beam_len), .rd_en(rd_en), .rd_addr(rd_addr), .beam_valid(beam_valid),
    .beam_data(beam_data), .fill_half(fill_half), .half_ready(half_ready), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int     cyc = 0;
  int     nvec = 0, nerr = 0;
  int     n_sent = 0, out_idx = 0;
  int     mwin = 0;
  int     wmod [NWIN][NCH];
  longint exp_sum [64];
  int     exp_cyc [64];
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int chd(input int seed, input int ch);
    return seed * (ch + 1) - 1000 * ch;
  endfunction

  function automatic int wgt0(input int w, input int c);
    int v = (w + 1) * (c + 3) * 65536;
    if (((w + c) % 3) == 0) v = -v;
    return v;
  endfunction

  function automatic longint model_beam(input int seed, input int win);
    longint acc = 0;
    for (int c = 0; c < NCH; c++) acc += longint'(chd(seed, c)) * longint'(wmod[win][c]);
    return acc;
  endfunction

  // Output monitor: value (R2) and arrival cycle (R3) of every beam sample
  always @(negedge clk) begin
    if (rst_n && beam_valid) begin
      if (out_idx < n_sent) begin
        chk("R2 beam sum", beam_data, exp_sum[out_idx]);
        chk("R3 latency", cyc, exp_cyc[out_idx]);
      end else begin
        chk("R3 extra output", out_idx, n_sent - 1);
      end
      out_idx++;
    end
  end

  task automatic send(input bit ls, input int win, input int seed);
    in_valid = 1'b1;
    line_start = ls;
    win_sel = 2'(win);
    for (int c = 0; c < NCH; c++) ch_data[c*32 +: 32] = chd(seed, c);
    if (ls) mwin = win;
    exp_sum[n_sent] = model_beam(seed, mwin);
    exp_cyc[n_sent] = cyc + LAT;
    n_sent++;
    @(negedge clk);
    in_valid = 1'b0;
    line_start = 1'b0;
  endtask

  task automatic load_wt(input int w, input int c, input int v);
    wt_we = 1'b1; wt_win = 2'(w); wt_ch = 3'(c); wt_data = v;
    wmod[w][c] = v;
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input longint e);
    rd_en = 1'b1; rd_addr = 2'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    longint hold;
    rst_n = 1'b0; in_valid = 0; line_start = 0; win_sel = 0; ch_data = '0;
    wt_we = 0; wt_win = 0; wt_ch = 0; wt_data = 0; beam_len = 3'd4; rd_en = 0; rd_addr = 0;
    idle(3);
    // R1: state during reset
    chk("R1 beam_valid in reset", beam_valid, 0);
    chk("R1 half_ready in reset", half_ready, 0);
    chk("R1 fill_half in reset", fill_half, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 half_ready after release", half_ready, 0);

    // R5: load every window table
    for (int w = 0; w < NWIN; w++)
      for (int c = 0; c < NCH; c++) load_wt(w, c, wgt0(w, c));

    // Vector table, first half: R2, R4 (selects without line start ignored)
    for (int i = 0; i < 4; i++) send(VECS[i].ls, int'(VECS[i].win), VECS[i].seed);
    idle(LAT + 3);
    chk("R6 swap to half 1", fill_half, 1);
    chk("R6 ready half 0", half_ready, 2'b01);
    for (int a = 0; a < 4; a++) rd_chk("R7 read half 0", a, exp_sum[a]);
    hold = rd_data;
    idle(2);
    chk("R7 rd_data holds", rd_data, hold);

    // Vector table, second half
    for (int i = 4; i < 8; i++) send(VECS[i].ls, int'(VECS[i].win), VECS[i].seed);
    idle(LAT + 3);
    chk("R6 swap back to half 0", fill_half, 0);
    chk("R6 ready half 1 only R8", half_ready, 2'b10);
    for (int a = 0; a < 4; a++) rd_chk("R7 read half 1", a, exp_sum[4 + a]);

    // R6: length 0 acts as 1
    beam_len = 3'd0;
    send(1'b0, 0, 1234);
    idle(LAT + 3);
    chk("R6 len0 swaps", fill_half, 1);
    chk("R6 len0 ready", half_ready, 2'b01);
    rd_chk("R7 len0 entry", 0, exp_sum[8]);

    // R6: length above DEPTH acts as DEPTH
    beam_len = 3'd7;
    for (int i = 0; i < 3; i++) send(1'b0, 0, -300 + 250 * i);
    idle(LAT + 3);
    chk("R6 clamp no early swap", fill_half, 1);
    chk("R6 clamp ready kept", half_ready, 2'b01);
    send(1'b0, 0, 999);
    idle(LAT + 3);
    chk("R6 clamp swap at DEPTH", fill_half, 0);
    chk("R6 clamp ready", half_ready, 2'b10);
    rd_chk("R7 clamp last entry", 3, exp_sum[12]);
    rd_chk("R7 clamp first entry", 0, exp_sum[9]);

    // R4: line_start without in_valid does not change the window
    line_start = 1'b1; win_sel = 2'd3;
    idle(1);
    line_start = 1'b0;
    send(1'b0, 1, 55);

    // R5: rewritten weight applies to later samples
    load_wt(mwin, 2, -123456);
    send(1'b0, 0, 900);
    // R3: gaps between samples
    idle(2);
    send(1'b1, 1, -4444);
    idle(1);
    send(1'b0, 3, 8);
    idle(LAT + 3);
    chk("R3 one output per sample", out_idx, n_sent);

    // R1: reset in operation
    rst_n = 1'b0;
    idle(2);
    chk("R1 beam_valid mid reset", beam_valid, 0);
    chk("R1 half_ready mid reset", half_ready, 0);
    chk("R1 fill_half mid reset", fill_half, 0);
    rst_n = 1'b1;
    idle(1);
    mwin = 0;  // R1: window returns to 0
    send(1'b0, 3, 4321);
    idle(LAT + 3);
    chk("R3 final output count", out_idx, n_sent);
    finish_run();
  end

endmodule